// File: doc/BRIEF.md
# Teletext packet acquisition filter

This block sits behind a data slicer and picks the wanted data packets out of a serial teletext stream. Serial bits arrive one per data-clock enable. While a validation window is open the block hunts for a programmed framing byte. Once it has locked, it groups the following bits into bytes. For the selected prefix type it walks the Hamming-protected prefix. It checks three 4-bit channel digits, works out how many data bytes the packet carries and, in fast mode, holds off storage until a page start has been seen. Each data byte of an accepted packet leaves on a one-cycle write strobe towards the buffer memory controller. Parity marking can replace the top bit of each byte.

A packet ends when its data length is used up, when a channel digit fails, or when the prefix check rejects it. In each case the block drops lock and hunts for the next framing byte. The framing byte itself, the prefix bytes and any bytes after the length limit are never forwarded.

Top module: `tlx_acq_filter`

## Requirements
- R1: After reset `out_valid` is low, and no byte is forwarded until a framing byte has been matched. A rejected or finished packet returns the block to hunting.
- R2: Bits are assembled LSB first, one per cycle with `bit_en` high. The framing match is tried only on bits taken while `win_in` is high. After a match, every group of eight further bits forms one byte.
- R3: Prefix types 011, 110 and 111 carry no prefix. Every byte after the framing byte is forwarded, up to `cfg_max_len` bytes, and a length of 0 forwards nothing.
- R4: The prefix bytes after the framing byte are: three channel digits for every prefixed type. Type 000 then has a continuity byte, a format byte and a two-byte page pair. Type 010 has a format byte and the pair. Type 001 has the pair only. Type 100 has a row nibble. Type 101 has a page-status nibble.
- R5: Hamming bytes carry data D1..D4 in bits 1, 3, 5, 7 (nibble bit 0 = D1). Bit0 = D1^D3^D4, bit2 = D1^D2^D4, bit4 = D1^D2^D3, and bit6 makes the byte's XOR zero. A single flipped bit is corrected. Two flipped bits are flagged as uncorrectable.
- R6: Channel digits 1..3 are compared with `cfg_chan[3:0]`, `[7:4]` and `[11:8]`. Any mismatch, or an uncorrectable digit, discards the packet. For type 100, bit 3 of the first digit is not compared.
- R7: For types 000 and 010 the format nibble n and `cfg_list` L give the length: n when n < 4, otherwise 4*(n-3)+L. `cfg_max_len` is used instead when `cfg_use_max` is 1, when the format byte is uncorrectable, or for types without a format byte.
- R8: With `cfg_parity` = 1, bit 7 of each forwarded byte is 1 if the received byte has an odd number of ones and 0 otherwise. With `cfg_parity` = 0 the byte is forwarded unchanged.
- R9: With `cfg_fast` = 1, packets are discarded until one carries a page start: a row nibble of 0 (type 100) or a status nibble with bit 0 set (type 101). That packet and all later ones are stored until reset. With `cfg_fast` = 0, no page-start test is made.
- R10: For the three-length prefix family the page start is the pair 0x01 then 0x9E. It is also accepted when either one of the two bytes has even parity and the other byte is exact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Data-clock enable, one serial bit per high cycle |
| ser_in | input | 1 | Serial data bit |
| win_in | input | 1 | Validation window for the framing search |
| cfg_frame | input | 8 | Framing byte value |
| cfg_ptype | input | 3 | Prefix type select |
| cfg_parity | input | 1 | Enable odd-parity marking in bit 7 |
| cfg_fast | input | 1 | Wait for a page start before storing |
| cfg_use_max | input | 1 | Force the maximum/default length |
| cfg_list | input | 2 | Format table column |
| cfg_max_len | input | 6 | Maximum/default data length, 0 to 63 |
| cfg_chan | input | 12 | Three 4-bit channel digits, first digit in bits 3:0 |
| out_valid | output | 1 | One-cycle write strobe for a data byte |
| out_data | output | 8 | Data byte to store |

## Verification
An internal fault shows up at the ports mainly as missing, extra or shifted write strobes within one packet time. A wrong bit count or lock state shifts every byte of the packet. A wrong prefix index corrupts the channel decision or the length. A stale page-start flag makes whole packets appear or vanish. The bench predicts each packet's forwarded bytes from the requirements, including bit-corrupted Hamming bytes and parity-errored page pairs. It compares them strobe by strobe and confirms that nothing is left pending a few cycles after every packet.

// File: rtl/tlx_pkg.sv
package tlx_pkg;
   typedef enum logic [1:0] {
      ST_HUNT = 2'd0,
      ST_PFX  = 2'd1,
      ST_DATA = 2'd2
   } acq_state_t;

   typedef enum logic [2:0] {
      PT_FR_LONG  = 3'd0,
      PT_FR_MED   = 3'd1,
      PT_FR_SHORT = 3'd2,
      PT_SPARE    = 3'd3,
      PT_UK       = 3'd4,
      PT_NA       = 3'd5,
      PT_RAW_A    = 3'd6,
      PT_RAW_B    = 3'd7
   } ptype_t;

   localparam logic [7:0] PAGE_MARK_A = 8'h01;
   localparam logic [7:0] PAGE_MARK_B = 8'h9E;
endpackage

// File: rtl/tlx_ham84_dec.sv
module tlx_ham84_dec (
   input  logic [7:0] code_i,
   output logic [3:0] nib_o,
   output logic       bad_o
);
   logic s1, s2, s3, s4;
   logic [3:0] raw;

   always_comb begin
      s1  = code_i[0] ^ code_i[1] ^ code_i[5] ^ code_i[7];
      s2  = code_i[2] ^ code_i[1] ^ code_i[3] ^ code_i[7];
      s3  = code_i[4] ^ code_i[1] ^ code_i[3] ^ code_i[5];
      s4  = ^code_i;
      raw = {code_i[7], code_i[5], code_i[3], code_i[1]};
      nib_o = raw;
      if (s4) begin
         nib_o[0] = raw[0] ^ (s1 & s2 & s3);
         nib_o[1] = raw[1] ^ (!s1 & s2 & s3);
         nib_o[2] = raw[2] ^ (s1 & !s2 & s3);
         nib_o[3] = raw[3] ^ (s1 & s2 & !s3);
      end
      bad_o = !s4 && (s1 || s2 || s3);
   end
endmodule

// File: rtl/tlx_fmt_map.sv
module tlx_fmt_map #(
   parameter int LEN_W = 6
) (
   input  logic [3:0]       nib_i,
   input  logic [1:0]       list_i,
   output logic [LEN_W-1:0] len_o
);
   localparam int RAW_W = 8;
   logic [RAW_W-1:0] len_raw;

   generate
      if (LEN_W < 6) begin : g_len_chk
         $error("tlx_fmt_map: LEN_W must hold values up to 51");
      end
   endgenerate

   always_comb begin
      if (nib_i < 4'd4)
         len_raw = RAW_W'(nib_i);
      else
         len_raw = ((RAW_W'(nib_i) - RAW_W'(3)) << 2) + RAW_W'(list_i);
      len_o = len_raw[LEN_W-1:0];
   end
endmodule

// File: rtl/tlx_pfx_layout.sv
module tlx_pfx_layout
   import tlx_pkg::*;
(
   input  logic [2:0] ptype_i,
   output logic       has_pfx_o,
   output logic       has_fmt_o,
   output logic       is_fr_o,
   output logic       is_uk_o,
   output logic       is_na_o,
   output logic [2:0] fmt_idx_o,
   output logic [2:0] pair_idx_o,
   output logic [2:0] last_idx_o
);
   always_comb begin
      has_pfx_o  = 1'b1;
      has_fmt_o  = 1'b0;
      is_fr_o    = 1'b0;
      is_uk_o    = 1'b0;
      is_na_o    = 1'b0;
      fmt_idx_o  = 3'd7;
      pair_idx_o = 3'd7;
      last_idx_o = 3'd3;
      case (ptype_t'(ptype_i))
         PT_FR_LONG: begin
            has_fmt_o = 1'b1; is_fr_o = 1'b1;
            fmt_idx_o = 3'd4; pair_idx_o = 3'd5; last_idx_o = 3'd6;
         end
         PT_FR_SHORT: begin
            has_fmt_o = 1'b1; is_fr_o = 1'b1;
            fmt_idx_o = 3'd3; pair_idx_o = 3'd4; last_idx_o = 3'd5;
         end
         PT_FR_MED: begin
            is_fr_o = 1'b1; pair_idx_o = 3'd3; last_idx_o = 3'd4;
         end
         PT_UK:   is_uk_o = 1'b1;
         PT_NA:   is_na_o = 1'b1;
         default: has_pfx_o = 1'b0;
      endcase
   end
endmodule

// File: rtl/tlx_frame_deser.sv
module tlx_frame_deser #(
   parameter int BYTE_W    = 8,
   parameter bit LSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_en_i,
   input  logic              ser_i,
   input  logic              win_i,
   input  logic [BYTE_W-1:0] frame_i,
   input  logic              drop_i,
   output logic              byte_stb_o,
   output logic [BYTE_W-1:0] byte_o,
   output logic              sync_o
);
   localparam int CNT_W = $clog2(BYTE_W);

   logic [BYTE_W-1:0] sh_q, sh_nxt;
   logic [CNT_W-1:0]  cnt_q;
   logic              locked_q;

   generate
      if (BYTE_W < 2) begin : g_w_chk
         $error("tlx_frame_deser: BYTE_W too small");
      end
      if (LSB_FIRST) begin : g_lsb
         assign sh_nxt = {ser_i, sh_q[BYTE_W-1:1]};
      end else begin : g_msb
         assign sh_nxt = {sh_q[BYTE_W-2:0], ser_i};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q       <= '0;
         cnt_q      <= '0;
         locked_q   <= 1'b0;
         byte_stb_o <= 1'b0;
         byte_o     <= '0;
         sync_o     <= 1'b0;
      end else begin
         byte_stb_o <= 1'b0;
         sync_o     <= 1'b0;
         if (bit_en_i) sh_q <= sh_nxt;
         if (drop_i) begin
            locked_q <= 1'b0;
         end else if (bit_en_i) begin
            if (!locked_q) begin
               if (win_i && (sh_nxt == frame_i)) begin
                  locked_q <= 1'b1;
                  cnt_q    <= '0;
                  sync_o   <= 1'b1;
               end
            end else if (cnt_q == CNT_W'(BYTE_W - 1)) begin
               cnt_q      <= '0;
               byte_stb_o <= 1'b1;
               byte_o     <= sh_nxt;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end

   // R2
   stb_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      byte_stb_o |-> $past(locked_q));

   // R2
   sync_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sync_o |-> ($past(win_i) && $past(bit_en_i) && !$past(locked_q)));
endmodule

// File: rtl/tlx_acq_filter.sv
module tlx_acq_filter
   import tlx_pkg::*;
#(
   parameter int BYTE_W    = 8,
   parameter int DIG_W     = 4,
   parameter int NDIG      = 3,
   parameter int LEN_W     = 6,
   parameter bit LSB_FIRST = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    bit_en,
   input  logic                    ser_in,
   input  logic                    win_in,
   input  logic [BYTE_W-1:0]       cfg_frame,
   input  logic [2:0]              cfg_ptype,
   input  logic                    cfg_parity,
   input  logic                    cfg_fast,
   input  logic                    cfg_use_max,
   input  logic [1:0]              cfg_list,
   input  logic [LEN_W-1:0]        cfg_max_len,
   input  logic [DIG_W*NDIG-1:0]   cfg_chan,
   output logic                    out_valid,
   output logic [BYTE_W-1:0]       out_data
);
   localparam int IDX_W = 3;

   generate
      if (BYTE_W != 8 || DIG_W != 4) begin : g_code_chk
         $error("tlx_acq_filter: Hamming 8/4 needs 8-bit bytes and 4-bit digits");
      end
      if (NDIG < 1 || NDIG > 3) begin : g_dig_chk
         $error("tlx_acq_filter: NDIG must fit before the prefix extras");
      end
   endgenerate

   logic              stb, sync, drop;
   logic [BYTE_W-1:0] byte_q;
   logic [3:0]        nib;
   logic              herr;
   logic [LEN_W-1:0]  fmt_len;
   logic              has_pfx, has_fmt, is_fr, is_uk, is_na;
   logic [IDX_W-1:0]  fmt_idx, pair_idx, last_idx;

   acq_state_t        state_q;
   logic [IDX_W-1:0]  idx_q;
   logic [LEN_W-1:0]  rem_q;
   logic [3:0]        fmt_nib_q;
   logic              fmt_bad_q;
   logic [BYTE_W-1:0] p1_q;
   logic              page_seen_q;

   tlx_frame_deser #(.BYTE_W(BYTE_W), .LSB_FIRST(LSB_FIRST)) i_deser (
      .clk(clk), .rst_n(rst_n), .bit_en_i(bit_en), .ser_i(ser_in),
      .win_i(win_in), .frame_i(cfg_frame), .drop_i(drop),
      .byte_stb_o(stb), .byte_o(byte_q), .sync_o(sync)
   );

   tlx_ham84_dec i_ham (.code_i(byte_q), .nib_o(nib), .bad_o(herr));

   tlx_fmt_map #(.LEN_W(LEN_W)) i_fmt (
      .nib_i(fmt_nib_q), .list_i(cfg_list), .len_o(fmt_len)
   );

   tlx_pfx_layout i_layout (
      .ptype_i(cfg_ptype), .has_pfx_o(has_pfx), .has_fmt_o(has_fmt),
      .is_fr_o(is_fr), .is_uk_o(is_uk), .is_na_o(is_na),
      .fmt_idx_o(fmt_idx), .pair_idx_o(pair_idx), .last_idx_o(last_idx)
   );

   logic [DIG_W-1:0] dig_ref, dig_mask;
   logic             in_digits, dig_bad, pair_page, page_now, go;
   logic [LEN_W-1:0] len_sel;

   always_comb begin
      dig_ref = cfg_chan[DIG_W-1:0];
      for (int k = 0; k < NDIG; k++)
         if (idx_q == IDX_W'(k)) dig_ref = cfg_chan[k*DIG_W +: DIG_W];
      dig_mask  = (is_uk && idx_q == '0) ? {1'b0, {(DIG_W-1){1'b1}}} : '1;
      in_digits = idx_q < IDX_W'(NDIG);
      dig_bad   = herr || (((nib ^ dig_ref) & dig_mask) != '0);
      pair_page = ((p1_q == PAGE_MARK_A) && (byte_q == PAGE_MARK_B)) ||
                  (!(^p1_q) && (byte_q == PAGE_MARK_B)) ||
                  ((p1_q == PAGE_MARK_A) && !(^byte_q));
      if (is_fr)      page_now = pair_page;
      else if (is_uk) page_now = !herr && (nib == 4'd0);
      else if (is_na) page_now = !herr && nib[0];
      else            page_now = 1'b0;
      len_sel = (has_fmt && !cfg_use_max && !fmt_bad_q) ? fmt_len : cfg_max_len;
      go = (!cfg_fast || page_seen_q || page_now) && (len_sel != '0);
      case (state_q)
         ST_HUNT: drop = sync && !has_pfx && (cfg_max_len == '0);
         ST_PFX:  drop = stb && ((in_digits && dig_bad) || (idx_q == last_idx && !go));
         ST_DATA: drop = stb && (rem_q == LEN_W'(1));
         default: drop = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_HUNT;
         idx_q       <= '0;
         rem_q       <= '0;
         fmt_nib_q   <= '0;
         fmt_bad_q   <= 1'b0;
         p1_q        <= '0;
         page_seen_q <= 1'b0;
         out_valid   <= 1'b0;
         out_data    <= '0;
      end else begin
         out_valid <= 1'b0;
         case (state_q)
            ST_HUNT: begin
               if (sync) begin
                  idx_q <= '0;
                  if (has_pfx) begin
                     state_q <= ST_PFX;
                  end else if (cfg_max_len != '0) begin
                     state_q <= ST_DATA;
                     rem_q   <= cfg_max_len;
                  end
               end
            end
            ST_PFX: begin
               if (stb) begin
                  if (in_digits && dig_bad) begin
                     state_q <= ST_HUNT;
                  end else if (idx_q == last_idx) begin
                     if (cfg_fast && page_now) page_seen_q <= 1'b1;
                     if (go) begin
                        state_q <= ST_DATA;
                        rem_q   <= len_sel;
                     end else begin
                        state_q <= ST_HUNT;
                     end
                  end else begin
                     idx_q <= idx_q + 1'b1;
                     if (has_fmt && idx_q == fmt_idx) begin
                        fmt_nib_q <= nib;
                        fmt_bad_q <= herr;
                     end
                     if (is_fr && idx_q == pair_idx) p1_q <= byte_q;
                  end
               end
            end
            ST_DATA: begin
               if (stb) begin
                  out_valid <= 1'b1;
                  out_data  <= cfg_parity ? {^byte_q, byte_q[BYTE_W-2:0]} : byte_q;
                  rem_q     <= rem_q - 1'b1;
                  if (rem_q == LEN_W'(1)) state_q <= ST_HUNT;
               end
            end
            default: state_q <= ST_HUNT;
         endcase
      end
   end

   // R1
   drop_hunt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      drop |=> (state_q == ST_HUNT));

   // R3
   out_in_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ($past(state_q) == ST_DATA));

   // R9
   fast_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && cfg_fast) |-> page_seen_q);
endmodule

// File: tb/test_tlx_acq_filter.sv
module test_tlx_acq_filter;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bit_en = 1'b0, ser_in = 1'b0, win_in = 1'b0;
   logic [7:0]  cfg_frame = 8'h27;
   logic [2:0]  cfg_ptype = 3'd6;
   logic        cfg_parity = 1'b0, cfg_fast = 1'b0, cfg_use_max = 1'b0;
   logic [1:0]  cfg_list = 2'd0;
   logic [5:0]  cfg_max_len = 6'd0;
   logic [11:0] cfg_chan = 12'h5A3;
   logic        out_valid;
   logic [7:0]  out_data;

   typedef struct { logic [7:0] d; string req; } exp_t;
   exp_t        sbq[$];
   logic [7:0]  pk[$];
   int          total = 0, bad = 0;
   string       cur_req = "R1";
   bit          done = 1'b0;

   always #10 clk = ~clk;

   tlx_acq_filter i_tlx_acq_filter (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .ser_in(ser_in), .win_in(win_in),
      .cfg_frame(cfg_frame), .cfg_ptype(cfg_ptype), .cfg_parity(cfg_parity),
      .cfg_fast(cfg_fast), .cfg_use_max(cfg_use_max), .cfg_list(cfg_list),
      .cfg_max_len(cfg_max_len), .cfg_chan(cfg_chan),
      .out_valid(out_valid), .out_data(out_data)
   );

   function automatic logic [7:0] ham(input logic [3:0] n);
      logic [7:0] b;
      b[1] = n[0]; b[3] = n[1]; b[5] = n[2]; b[7] = n[3];
      b[0] = n[0] ^ n[2] ^ n[3];
      b[2] = n[0] ^ n[1] ^ n[3];
      b[4] = n[0] ^ n[1] ^ n[2];
      b[6] = b[0] ^ b[1] ^ b[2] ^ b[3] ^ b[4] ^ b[5] ^ b[7];
      return b;
   endfunction

   function automatic logic [7:0] pmark(input logic [7:0] b);
      return {^b, b[6:0]};
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic expect_b(input logic [7:0] d, input string req);
      exp_t e;
      e.d = d; e.req = req;
      sbq.push_back(e);
   endtask

   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         if (sbq.size() == 0) begin
            chk(1'b0, cur_req, "unexpected write strobe", out_data, 0);
         end else begin
            exp_t e;
            e = sbq.pop_front();
            chk(out_data == e.d, e.req, "forwarded byte", out_data, e.d);
         end
      end
   end

   task automatic tx_bit(input logic b);
      @(negedge clk); ser_in = b; bit_en = 1'b1;
      @(negedge clk); bit_en = 1'b0;
   endtask

   task automatic tx_byte(input logic [7:0] b, input logic w);
      win_in = w;
      for (int i = 0; i < 8; i++) tx_bit(b[i]);
      win_in = 1'b0;
   endtask

   task automatic tx_pkt(input logic w);
      tx_byte(8'h55, 1'b0);
      tx_byte(8'h55, 1'b0);
      tx_byte(cfg_frame, w);
      foreach (pk[i]) tx_byte(pk[i], 1'b0);
      for (int i = 0; i < 2; i++) tx_byte(8'h00, 1'b0);
   endtask

   task automatic settle(input string req);
      repeat (6) @(negedge clk);
      chk(sbq.size() == 0, req, "bytes still pending", sbq.size(), 0);
      sbq.delete();
   endtask

   task automatic do_reset();
      @(negedge clk); rst_n = 1'b0;
      repeat (3) @(negedge clk); rst_n = 1'b1;
   endtask

   task automatic set_cfg(input logic [2:0] pt, input logic par, input logic fast,
                          input logic um, input logic [1:0] lst, input logic [5:0] ml);
      cfg_ptype = pt; cfg_parity = par; cfg_fast = fast;
      cfg_use_max = um; cfg_list = lst; cfg_max_len = ml;
   endtask

   task automatic add_hdr(input logic [7:0] c1, input logic [7:0] c2, input logic [7:0] c3);
      pk.delete();
      pk.push_back(c1); pk.push_back(c2); pk.push_back(c3);
   endtask

   task automatic add_data(input int n, input logic [7:0] base);
      for (int i = 0; i < n; i++) pk.push_back(base + 8'(i * 7));
   endtask

   task automatic exp_data(input int n, input logic [7:0] base, input string req);
      for (int i = 0; i < n; i++) expect_b(base + 8'(i * 7), req);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL %s watchdog: actual=timeout expected=finish", cur_req);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      do_reset();
      // R1: reset state
      @(negedge clk);
      chk(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);

      // R3: no prefix, length 5 out of 7 bytes
      cur_req = "R3";
      set_cfg(3'd6, 0, 0, 0, 0, 6'd5);
      pk.delete(); add_data(7, 8'h11); exp_data(5, 8'h11, "R3");
      tx_pkt(1'b1); settle("R3");
      // R3: length 0 forwards nothing
      set_cfg(3'd7, 0, 0, 0, 0, 6'd0);
      tx_pkt(1'b1); settle("R3");
      set_cfg(3'd7, 0, 0, 0, 0, 6'd1);
      expect_b(8'h11, "R3"); tx_pkt(1'b1); settle("R3");

      // R2: framing byte outside window is not matched
      cur_req = "R2";
      set_cfg(3'd6, 0, 0, 0, 0, 6'd4);
      tx_pkt(1'b0); settle("R2");
      // R2: byte alignment after a good framing match
      expect_b(8'h11, "R2"); expect_b(8'h18, "R2"); expect_b(8'h1F, "R2"); expect_b(8'h26, "R2");
      tx_pkt(1'b1); settle("R2");

      // R6 R4: North American prefix, slow mode, matching channel
      cur_req = "R6";
      set_cfg(3'd5, 0, 0, 0, 0, 6'd3);
      add_hdr(ham(4'h3), ham(4'hA), ham(4'h5)); pk.push_back(ham(4'h0));
      add_data(4, 8'h40); exp_data(3, 8'h40, "R4");
      tx_pkt(1'b1); settle("R4");
      // R6: second digit mismatch
      add_hdr(ham(4'h3), ham(4'hB), ham(4'h5)); pk.push_back(ham(4'h0)); add_data(4, 8'h40);
      tx_pkt(1'b1); settle("R6");
      // R6: third digit mismatch
      add_hdr(ham(4'h3), ham(4'hA), ham(4'h4)); pk.push_back(ham(4'h0)); add_data(4, 8'h40);
      tx_pkt(1'b1); settle("R6");

      // R6: UK ignores bit 3 of first digit but not bit 2
      set_cfg(3'd4, 0, 0, 0, 0, 6'd2);
      add_hdr(ham(4'hB), ham(4'hA), ham(4'h5)); pk.push_back(ham(4'h7));
      add_data(3, 8'h60); exp_data(2, 8'h60, "R6");
      tx_pkt(1'b1); settle("R6");
      add_hdr(ham(4'h7), ham(4'hA), ham(4'h5)); pk.push_back(ham(4'h7)); add_data(3, 8'h60);
      tx_pkt(1'b1); settle("R6");

      // R5: single-bit error corrected, double error rejected
      cur_req = "R5";
      set_cfg(3'd5, 0, 0, 0, 0, 6'd2);
      add_hdr(ham(4'h3) ^ 8'h20, ham(4'hA) ^ 8'h04, ham(4'h5) ^ 8'h80);
      pk.push_back(ham(4'h1)); add_data(3, 8'h70); exp_data(2, 8'h70, "R5");
      tx_pkt(1'b1); settle("R5");
      add_hdr(ham(4'h3) ^ 8'h0A, ham(4'hA), ham(4'h5)); pk.push_back(ham(4'h1)); add_data(3, 8'h70);
      tx_pkt(1'b1); settle("R5");

      // R7: long prefix, format 5 with list 2 gives 10
      cur_req = "R7";
      set_cfg(3'd0, 0, 0, 0, 2'd2, 6'd4);
      add_hdr(ham(4'h3), ham(4'hA), ham(4'h5));
      pk.push_back(ham(4'h0)); pk.push_back(ham(4'h5)); pk.push_back(8'h01); pk.push_back(8'h9E);
      add_data(12, 8'h21); exp_data(10, 8'h21, "R7");
      tx_pkt(1'b1); settle("R7");
      // R7: forced maximum length
      cfg_use_max = 1'b1;
      exp_data(4, 8'h21, "R7"); tx_pkt(1'b1); settle("R7");
      // R7: uncorrectable format byte falls back to maximum
      set_cfg(3'd0, 0, 0, 0, 2'd2, 6'd2);
      add_hdr(ham(4'h3), ham(4'hA), ham(4'h5));
      pk.push_back(ham(4'h0)); pk.push_back(ham(4'h5) ^ 8'h0A); pk.push_back(8'h01); pk.push_back(8'h9E);
      add_data(12, 8'h21); exp_data(2, 8'h21, "R7");
      tx_pkt(1'b1); settle("R7");
      // R7 R4: medium prefix has no format byte
      set_cfg(3'd1, 0, 0, 0, 2'd3, 6'd3);
      add_hdr(ham(4'h3), ham(4'hA), ham(4'h5)); pk.push_back(8'h01); pk.push_back(8'h9E);
      add_data(5, 8'h90); exp_data(3, 8'h90, "R4");
      tx_pkt(1'b1); settle("R4");
      // R7: short prefix, format 2 (below 4) gives 2
      set_cfg(3'd2, 0, 0, 0, 2'd1, 6'd9);
      add_hdr(ham(4'h3), ham(4'hA), ham(4'h5));
      pk.push_back(ham(4'h2)); pk.push_back(8'h55); pk.push_back(8'h77);
      add_data(5, 8'hA0); exp_data(2, 8'hA0, "R7");
      tx_pkt(1'b1); settle("R7");

      // R8: parity marking on and off
      cur_req = "R8";
      set_cfg(3'd5, 1, 0, 0, 0, 6'd4);
      add_hdr(ham(4'h3), ham(4'hA), ham(4'h5)); pk.push_back(ham(4'h0));
      pk.push_back(8'h01); pk.push_back(8'h03); pk.push_back(8'h80); pk.push_back(8'hFF);
      expect_b(pmark(8'h01), "R8"); expect_b(pmark(8'h03), "R8");
      expect_b(pmark(8'h80), "R8"); expect_b(pmark(8'hFF), "R8");
      tx_pkt(1'b1); settle("R8");
      cfg_parity = 1'b0;
      expect_b(8'h01, "R8"); expect_b(8'h03, "R8"); expect_b(8'h80, "R8"); expect_b(8'hFF, "R8");
      tx_pkt(1'b1); settle("R8");

      // R9: fast mode, North American status bit
      cur_req = "R9";
      do_reset();
      set_cfg(3'd5, 0, 1, 0, 0, 6'd2);
      add_hdr(ham(4'h3), ham(4'hA), ham(4'h5)); pk.push_back(ham(4'h2)); add_data(3, 8'h30);
      tx_pkt(1'b1); settle("R9");
      add_hdr(ham(4'h3), ham(4'hA), ham(4'h5)); pk.push_back(ham(4'h1)); add_data(3, 8'h30);
      exp_data(2, 8'h30, "R9"); tx_pkt(1'b1); settle("R9");
      add_hdr(ham(4'h3), ham(4'hA), ham(4'h5)); pk.push_back(ham(4'h2)); add_data(3, 8'h30);
      exp_data(2, 8'h30, "R9"); tx_pkt(1'b1); settle("R9");
      // R9: fast mode, UK row 0
      do_reset();
      set_cfg(3'd4, 0, 1, 0, 0, 6'd2);
      add_hdr(ham(4'h3), ham(4'hA), ham(4'h5)); pk.push_back(ham(4'h4)); add_data(3, 8'hB0);
      tx_pkt(1'b1); settle("R9");
      add_hdr(ham(4'h3), ham(4'hA), ham(4'h5)); pk.push_back(ham(4'h0)); add_data(3, 8'hB0);
      exp_data(2, 8'hB0, "R9"); tx_pkt(1'b1); settle("R9");

      // R10: French pair with both bytes bad, then one bad
      cur_req = "R10";
      do_reset();
      set_cfg(3'd2, 0, 1, 0, 0, 6'd9);
      add_hdr(ham(4'h3), ham(4'hA), ham(4'h5));
      pk.push_back(ham(4'h2)); pk.push_back(8'h03); pk.push_back(8'h1E); add_data(4, 8'hC1);
      tx_pkt(1'b1); settle("R10");
      add_hdr(ham(4'h3), ham(4'hA), ham(4'h5));
      pk.push_back(ham(4'h2)); pk.push_back(8'h01); pk.push_back(8'h1E); add_data(4, 8'hC1);
      exp_data(2, 8'hC1, "R10"); tx_pkt(1'b1); settle("R10");
      do_reset();
      set_cfg(3'd2, 0, 1, 0, 0, 6'd9);
      add_hdr(ham(4'h3), ham(4'hA), ham(4'h5));
      pk.push_back(ham(4'h2)); pk.push_back(8'h03); pk.push_back(8'h9E); add_data(4, 8'hD1);
      exp_data(2, 8'hD1, "R10"); tx_pkt(1'b1); settle("R10");

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule